// File: doc/BRIEF.md
# Dual Micro-Op Queue Allocator

This block sits between a fetch queue and the dispatch logic of an out-of-order core. Each cycle it is offered up to three decoded micro-operations. Lane 0 holds the oldest of them. The block steers each one by its class tag into one of two in-order FIFOs. The address FIFO takes only load-address and store-address operations. The main FIFO takes every other operation, store-data included.

Allocation follows program order. The block writes the oldest offered micro-operations that fit and stops at the first one that cannot be written. It reports that number back to the fetch queue, which drops exactly that many from its head. A full target queue therefore holds back the other queue as well.

Dispatch logic drains each FIFO through its own read port, one entry per cycle. The two ports are independent. Both FIFOs are emptied by reset and by a one-cycle flush. Register and reorder-buffer reservation is treated as always granted.

Top module: `uop_steer_alloc`

## Requirements
- R1: Up to three micro-operations are taken per cycle, and `take_cnt` (0 to 3) gives how many lanes were accepted in the current cycle, counted from lane 0.
- R2: A class tag of 1 (load address) or 2 (store address) routes a micro-operation to the address FIFO. Every other tag value goes to the main FIFO, including 3 (store data).
- R3: The address FIFO holds 16 entries and the main FIFO holds 32. Their occupancies are reported on `aq_count` and `mq_count`.
- R4: Neither occupancy ever exceeds its depth. Free slots are counted per FIFO for the whole group, so k address micro-operations in one group need k free address slots.
- R5: A lane is accepted only if it is valid and every older lane in the group was accepted. The first invalid lane ends the group.
- R6: When the next micro-operation's target FIFO has no room, allocation stops there. No younger micro-operation enters either FIFO, even if its own FIFO has room.
- R7: Each FIFO reads out in arrival order. `*_rd_valid` is high exactly when the FIFO is non-empty, `*_rd_data` shows its oldest entry, and `*_rd_en` removes that entry at the clock edge.
- R8: Room is judged from the occupancy at the start of the cycle. An entry read out in the same cycle does not free a slot for that cycle's group.
- R9: Reset and `flush` empty both FIFOs. While `flush` is high, `take_cnt` is 0 and reads remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties both FIFOs at the next edge |
| in_valid | input | 3 | Per-lane valid; lane 0 is oldest |
| in_cls | input | 9 | Per-lane 3-bit class tag, lane i at bits [3i+2:3i] |
| in_data | input | 48 | Per-lane 16-bit payload, lane i at bits [16i+15:16i] |
| take_cnt | output | 2 | Number of lanes accepted this cycle |
| aq_rd_en | input | 1 | Remove the head of the address FIFO |
| aq_rd_valid | output | 1 | Address FIFO non-empty |
| aq_rd_data | output | 16 | Head of the address FIFO |
| aq_count | output | 5 | Address FIFO occupancy |
| mq_rd_en | input | 1 | Remove the head of the main FIFO |
| mq_rd_valid | output | 1 | Main FIFO non-empty |
| mq_rd_data | output | 16 | Head of the main FIFO |
| mq_count | output | 6 | Main FIFO occupancy |

## Verification
The hardest case to reach from the ports is a group that mixes both classes while one FIFO sits exactly at or near its limit. Only that case shows a younger operation being refused although its own FIFO has room. It also shows a same-cycle read failing to make space. The stimulus gets there by filling the address FIFO with address-only groups while both read enables are held low. It then offers mixed groups and a simultaneous read. After that, long random stretches with skewed class mixes and read rates keep both FIFOs drifting around their full and empty points.

// File: rtl/uop_steer_alloc.sv
module uop_steer_alloc #(
  parameter int LANES    = 3,
  parameter int DW       = 16,
  parameter int CW       = 3,
  parameter int AQ_DEPTH = 16,
  parameter int MQ_DEPTH = 32,
  parameter logic [CW-1:0] LD_ADDR = 3'd1,
  parameter logic [CW-1:0] ST_ADDR = 3'd2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [LANES-1:0]         in_valid,
  input  logic [LANES*CW-1:0]      in_cls,
  input  logic [LANES*DW-1:0]      in_data,
  output logic [$clog2(LANES+1)-1:0] take_cnt,
  input  logic                     aq_rd_en,
  output logic                     aq_rd_valid,
  output logic [DW-1:0]            aq_rd_data,
  output logic [$clog2(AQ_DEPTH+1)-1:0] aq_count,
  input  logic                     mq_rd_en,
  output logic                     mq_rd_valid,
  output logic [DW-1:0]            mq_rd_data,
  output logic [$clog2(MQ_DEPTH+1)-1:0] mq_count
);
  localparam int AW  = $clog2(AQ_DEPTH);
  localparam int MW  = $clog2(MQ_DEPTH);
  localparam int ACW = $clog2(AQ_DEPTH+1);
  localparam int MCW = $clog2(MQ_DEPTH+1);
  localparam int TW  = $clog2(LANES+1);

  logic [DW-1:0] amem [AQ_DEPTH];
  logic [DW-1:0] mmem [MQ_DEPTH];
  logic [AW-1:0] a_wp, a_rp;
  logic [MW-1:0] m_wp, m_rp;

  logic [LANES-1:0] is_a, lane_ok;
  logic [ACW-1:0]   a_off [LANES];
  logic [MCW-1:0]   m_off [LANES];
  logic [ACW-1:0]   a_push, a_free;
  logic [MCW-1:0]   m_push, m_free;
  logic [TW-1:0]    take;
  logic             a_pop, m_pop;

  for (genvar g = 0; g < LANES; g++) begin : g_cls
    assign is_a[g] = (in_cls[g*CW +: CW] == LD_ADDR) || (in_cls[g*CW +: CW] == ST_ADDR);
  end

  assign a_free = ACW'(AQ_DEPTH) - aq_count;
  assign m_free = MCW'(MQ_DEPTH) - mq_count;

  always_comb begin
    logic run;
    run     = !flush;
    a_push  = '0;
    m_push  = '0;
    take    = '0;
    lane_ok = '0;
    for (int i = 0; i < LANES; i++) begin
      a_off[i] = a_push;
      m_off[i] = m_push;
      if (run && in_valid[i] && (is_a[i] ? (a_push < a_free) : (m_push < m_free))) begin
        lane_ok[i] = 1'b1;
        take       = take + TW'(1);
        if (is_a[i]) a_push = a_push + ACW'(1);
        else         m_push = m_push + MCW'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign take_cnt    = take;
  assign aq_rd_valid = (aq_count != '0);
  assign mq_rd_valid = (mq_count != '0);
  assign aq_rd_data  = amem[a_rp];
  assign mq_rd_data  = mmem[m_rp];
  assign a_pop       = aq_rd_en && aq_rd_valid && !flush;
  assign m_pop       = mq_rd_en && mq_rd_valid && !flush;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_ok[i] && is_a[i])  amem[a_wp + AW'(a_off[i])] <= in_data[i*DW +: DW];
      if (lane_ok[i] && !is_a[i]) mmem[m_wp + MW'(m_off[i])] <= in_data[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_wp <= '0; a_rp <= '0; aq_count <= '0;
      m_wp <= '0; m_rp <= '0; mq_count <= '0;
    end else if (flush) begin
      a_wp <= '0; a_rp <= '0; aq_count <= '0;
      m_wp <= '0; m_rp <= '0; mq_count <= '0;
    end else begin
      a_wp     <= a_wp + AW'(a_push);
      m_wp     <= m_wp + MW'(m_push);
      a_rp     <= a_rp + AW'(a_pop);
      m_rp     <= m_rp + MW'(m_pop);
      aq_count <= aq_count + a_push - ACW'(a_pop);
      mq_count <= mq_count + m_push - MCW'(m_pop);
    end
  end

  AST_AQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) aq_count <= ACW'(AQ_DEPTH)); // R4
  AST_MQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) mq_count <= MCW'(MQ_DEPTH)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (aq_count == '0 && mq_count == '0)); // R9
  AST_FLUSH_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) flush |-> take_cnt == '0); // R9
  AST_TAKE_NEEDS_LANE0: assert property (@(posedge clk) disable iff (!rst_n) (take_cnt != '0) |-> in_valid[0]); // R5
  AST_FULL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (aq_count == ACW'(AQ_DEPTH) && in_valid[0] && is_a[0]) |-> take_cnt == '0); // R6
  AST_AQ_RISE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n || flush)
    aq_rd_valid && aq_rd_en |=> aq_count <= $past(aq_count) + ACW'(LANES) - ACW'(1)); // R7
endmodule

// File: tb/tb_uop_steer_alloc.sv
module tb_uop_steer_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3, DW = 16, CW = 3, AQD = 16, MQD = 32;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [LANES-1:0] in_valid = '0;
  logic [LANES*CW-1:0] in_cls = '0;
  logic [LANES*DW-1:0] in_data = '0;
  logic [1:0] take_cnt;
  logic aq_rd_en = 0, mq_rd_en = 0;
  logic aq_rd_valid, mq_rd_valid;
  logic [DW-1:0] aq_rd_data, mq_rd_data;
  logic [4:0] aq_count;
  logic [5:0] mq_count;

  uop_steer_alloc dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_cls(in_cls),
    .in_data(in_data), .take_cnt(take_cnt), .aq_rd_en(aq_rd_en), .aq_rd_valid(aq_rd_valid),
    .aq_rd_data(aq_rd_data), .aq_count(aq_count), .mq_rd_en(mq_rd_en),
    .mq_rd_valid(mq_rd_valid), .mq_rd_data(mq_rd_data), .mq_count(mq_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  logic [DW-1:0] aq_m[$], mq_m[$];
  logic [DW-1:0] seq = 16'h100;
  int exp_take;
  bit done = 0;

  function automatic bit addr_cls(logic [CW-1:0] c);
    return c == 3'd1 || c == 3'd2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_take();
    int na = 0, nm = 0, t = 0;
    if (flush) return 0;
    for (int i = 0; i < LANES; i++) begin
      if (!in_valid[i]) break;
      if (addr_cls(in_cls[i*CW +: CW])) begin
        if (na >= AQD - aq_m.size()) break;
        na++;
      end else begin
        if (nm >= MQD - mq_m.size()) break;
        nm++;
      end
      t++;
    end
    return t;
  endfunction

  task automatic drive(logic [2:0] v, logic [2:0] c0, logic [2:0] c1, logic [2:0] c2,
                       bit ar, bit mr, bit fl);
    @(negedge clk);
    in_valid = v; in_cls = {c2, c1, c0};
    for (int i = 0; i < LANES; i++) begin in_data[i*DW +: DW] = seq; seq++; end
    aq_rd_en = ar; mq_rd_en = mr; flush = fl;
    #1;
    exp_take = model_take();
    chk(int'(take_cnt) == exp_take, "R1 take_cnt", take_cnt, exp_take);
    chk(int'(aq_count) == aq_m.size(), "R4 aq_count", aq_count, aq_m.size());
    chk(int'(mq_count) == mq_m.size(), "R4 mq_count", mq_count, mq_m.size());
    chk(aq_rd_valid == (aq_m.size() != 0), "R7 aq_rd_valid", aq_rd_valid, aq_m.size() != 0);
    chk(mq_rd_valid == (mq_m.size() != 0), "R7 mq_rd_valid", mq_rd_valid, mq_m.size() != 0);
    if (aq_m.size() != 0) chk(aq_rd_data == aq_m[0], "R7 aq_rd_data", aq_rd_data, aq_m[0]);
    if (mq_m.size() != 0) chk(mq_rd_data == mq_m[0], "R7 mq_rd_data", mq_rd_data, mq_m[0]);
  endtask

  task automatic commit();
    @(posedge clk);
    if (flush) begin
      aq_m.delete(); mq_m.delete();
    end else begin
      if (aq_rd_en && aq_m.size() != 0) void'(aq_m.pop_front());
      if (mq_rd_en && mq_m.size() != 0) void'(mq_m.pop_front());
      for (int i = 0; i < exp_take; i++) begin
        if (addr_cls(in_cls[i*CW +: CW])) aq_m.push_back(in_data[i*DW +: DW]);
        else mq_m.push_back(in_data[i*DW +: DW]);
      end
    end
  endtask

  task automatic step(logic [2:0] v, logic [2:0] c0, logic [2:0] c1, logic [2:0] c2,
                      bit ar, bit mr, bit fl);
    drive(v, c0, c1, c2, ar, mr, fl);
    commit();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    drive(3'b000, 0, 0, 0, 0, 0, 0);
    chk(aq_count == 0 && mq_count == 0 && !aq_rd_valid && !mq_rd_valid, "R9 reset empty", aq_count + mq_count, 0);
    commit();

    // fill the address FIFO: 3,3,3,3,3 then 1
    for (int k = 0; k < 5; k++) step(3'b111, 1, 2, 1, 0, 0, 0);
    drive(3'b111, 2, 1, 2, 0, 0, 0);
    chk(take_cnt == 1, "R4 one free address slot", take_cnt, 1);
    commit();
    drive(3'b000, 0, 0, 0, 0, 0, 0);
    chk(aq_count == 16, "R3 address depth", aq_count, 16);
    commit();

    drive(3'b111, 0, 1, 0, 0, 0, 0);
    chk(take_cnt == 1, "R6 younger main uop blocked", take_cnt, 1);
    commit();
    drive(3'b111, 1, 0, 0, 1, 0, 0);
    chk(take_cnt == 0, "R8 same-cycle read gives no room", take_cnt, 0);
    commit();
    drive(3'b111, 3, 3, 7, 0, 0, 0);
    chk(take_cnt == 3, "R2 store data to main", take_cnt, 3);
    commit();
    drive(3'b101, 0, 0, 0, 0, 0, 0);
    chk(take_cnt == 1, "R5 invalid lane ends group", take_cnt, 1);
    commit();

    // fill the main FIFO
    for (int k = 0; k < 12; k++) step(3'b111, 0, 3, 5, 0, 0, 0);
    drive(3'b000, 0, 0, 0, 0, 0, 0);
    chk(mq_count == 32, "R3 main depth", mq_count, 32);
    commit();

    // drain a few and check order via model
    for (int k = 0; k < 20; k++) step(3'b000, 0, 0, 0, 1, 1, 0);

    drive(3'b111, 1, 0, 1, 1, 1, 1);
    chk(take_cnt == 0, "R9 flush takes nothing", take_cnt, 0);
    commit();
    drive(3'b000, 0, 0, 0, 0, 0, 0);
    chk(aq_count == 0 && mq_count == 0, "R9 flush empties", aq_count + mq_count, 0);
    commit();

    for (int k = 0; k < 4000; k++) begin
      logic [2:0] v, c0, c1, c2;
      int rate;
      rate = (k / 500) % 4;
      v  = 3'($urandom);
      c0 = 3'($urandom_range(0, 7));
      c1 = (rate == 1) ? 3'd1 : 3'($urandom_range(0, 7));
      c2 = (rate == 2) ? 3'd3 : 3'($urandom_range(0, 7));
      step(v, c0, c1, c2,
           ($urandom_range(0, 3) < rate), ($urandom_range(0, 3) < (3 - rate)),
           ($urandom_range(0, 299) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule